// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block sits between a processor read port and a slower byte-wide memory port. It keeps a small direct-mapped store of cache lines. Each line holds a valid flag, a tag and a block of `2^OFF_W` bytes. The processor presents a byte address. The address is split into a block offset, a line index and a tag. When the indexed line is valid and its tag agrees with the address, the byte that the offset selects is returned in the same cycle.

On a miss the processor is held off and the whole block is fetched from memory one byte per beat. The fetch starts at the block-aligned address. The fetched block is written into the indexed line, replacing whatever that line held before. The requested byte is delivered in the following cycle.

The requester keeps `cpu_req` and `cpu_addr` steady until it sees `cpu_ready`. A new request is looked up only while the controller is idle.

Top module: `rcache_top`

## Requirements
- R1: The address splits as follows: bits [OFF_W-1:0] are the byte offset, the next IDX_W bits are the line index, and the remaining upper bits are the tag. With the defaults (8-bit address, 2-bit offset, 2-bit index), 0x9B is byte 3 of line 2 with tag 0x9.
- R2: After reset every line is invalid, so the first read of any address misses. While reset is held, and with no request, `cpu_ready` and `mem_req` are both 0.
- R3: A hit asserts `cpu_ready` in the same cycle as the request, with the selected byte on `cpu_rdata`. It does not raise `mem_req` in the next cycle.
- R4: On a miss, `cpu_ready` stays 0 while `mem_req` is 1. `cpu_ready` rises in the cycle after the beat that carries the last byte of the block, and `mem_req` is 0 in that cycle.
- R5: A fill issues exactly 2^OFF_W beats. The first beat has offset 0, and the offset goes up by one after each accepted beat (`mem_valid`=1). The tag and index bits of `mem_addr` stay constant for the whole fill.
- R6: A fill writes the address tag, the fetched block and a set valid flag into the line. After it, a read of any byte of that block hits.
- R7: Byte i of a memory block is placed in byte i of the line, and the offset picks that byte on `cpu_rdata`.
- R8: A miss overwrites the line at its index. An address with the previous tag at that index then misses again.
- R9: Cycles with `mem_valid`=0 during a fill hold the beat and the address. A request presented in the cycle right after a delivery is treated as a new lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | Requested byte is on `cpu_rdata` this cycle |
| cpu_rdata | output | BYTE_W | Returned byte |
| mem_req | output | 1 | Fill in progress, a beat is wanted |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_valid | input | 1 | `mem_rdata` carries the current beat |
| mem_rdata | input | BYTE_W | Byte returned by memory |

## Verification
A valid flag or tag that is wrong shows up as a wrong hit/miss decision in the first cycle of the request. A wrongly kept line answers immediately, in zero cycles, with a stale byte. A line that should be kept but is lost costs a full fill of 2^OFF_W+1 cycles. The bench keeps its own model of line tags, so it predicts each latency exactly. A bad beat counter or a bad fill buffer shows on `mem_addr` at the next beat, or as a wrong byte when the line is first read. A broken offset multiplexer shows as a wrong `cpu_rdata` on the very hit that selects the bad byte.

// File: rtl/rcache_pkg.sv
package rcache_pkg;

    localparam int unsigned RC_ADDR_W = 8;
    localparam int unsigned RC_IDX_W  = 2;
    localparam int unsigned RC_OFF_W  = 2;
    localparam int unsigned RC_BYTE_W = 8;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_FETCH   = 2'd1,
        FS_DELIVER = 2'd2
    } fill_state_e;

    function automatic int unsigned rc_tag_w(int unsigned aw, int unsigned iw, int unsigned ow);
        return aw - iw - ow;
    endfunction

endpackage

// File: rtl/rcache_store.sv
module rcache_store #(
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned BLK_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_blk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_blk
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [BLK_W-1:0] blk_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[g] <= 1'b0;
            end else if (sel) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[g] <= wr_tag;
                blk_q[g] <= wr_blk;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_blk   = blk_q[rd_idx];

endmodule

// File: rtl/rcache_lookup.sv
module rcache_lookup #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned BLK_N = 1 << OFF_W,
    localparam int unsigned BLK_W = BLK_N * BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              line_valid,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [BLK_W-1:0]  line_blk,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic              hit,
    output logic [BYTE_W-1:0] byte_out
);
    logic [OFF_W-1:0]  off;
    logic [BYTE_W-1:0] lanes [BLK_N];

    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];

    assign hit = line_valid && (line_tag == tag);

    for (genvar g = 0; g < BLK_N; g++) begin : g_lane
        assign lanes[g] = line_blk[g*BYTE_W +: BYTE_W];
    end

    assign byte_out = lanes[off];

endmodule

// File: rtl/rcache_fill.sv
module rcache_fill
    import rcache_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int unsigned BLK_N = 1 << OFF_W,
    localparam int unsigned BLK_W = BLK_N * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_valid,
    input  logic [BYTE_W-1:0] mem_rdata,
    output fill_state_e       state,
    output logic [ADDR_W-1:0] held_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [BLK_W-1:0]  wr_blk
);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLK_N - 1);

    fill_state_e       state_q, state_d;
    logic [OFF_W-1:0]  beat_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BLK_W-1:0]  buf_q;
    logic              take;
    logic              last;

    assign take = (state_q == FS_FETCH) && mem_valid;
    assign last = take && (beat_q == LAST_BEAT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:    if (start) state_d = FS_FETCH;
            FS_FETCH:   if (last)  state_d = FS_DELIVER;
            FS_DELIVER: state_d = FS_IDLE;
            default:    state_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            beat_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_IDLE && start) begin
                addr_q <= start_addr;
                beat_q <= '0;
            end else if (take) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            buf_q[beat_q*BYTE_W +: BYTE_W] <= mem_rdata;
        end
    end

    assign state     = state_q;
    assign held_addr = addr_q;
    assign mem_req   = (state_q == FS_FETCH);
    assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], beat_q};

    assign wr_en  = last;
    assign wr_idx = addr_q[OFF_W +: IDX_W];
    assign wr_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign wr_blk = {mem_rdata, buf_q[BLK_W-BYTE_W-1:0]};

endmodule

// File: rtl/rcache_top.sv
module rcache_top
    import rcache_pkg::*;
#(
    parameter int unsigned ADDR_W = RC_ADDR_W,
    parameter int unsigned IDX_W  = RC_IDX_W,
    parameter int unsigned OFF_W  = RC_OFF_W,
    parameter int unsigned BYTE_W = RC_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int unsigned TAG_W = rc_tag_w(ADDR_W, IDX_W, OFF_W);
    localparam int unsigned BLK_W = (1 << OFF_W) * BYTE_W;

    fill_state_e       state;
    logic [ADDR_W-1:0] held_addr;
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_blk;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [BLK_W-1:0]  wr_blk;
    logic              idle;
    logic              start;

    assign idle      = (state == FS_IDLE);
    assign look_addr = idle ? cpu_addr : held_addr;
    assign start     = idle && cpu_req && !hit;
    assign cpu_ready = (idle && cpu_req && hit) || (state == FS_DELIVER);

    rcache_store #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .BLK_W (BLK_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_blk   (line_blk),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_blk   (wr_blk)
    );

    rcache_lookup #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .BYTE_W (BYTE_W)
    ) u_lookup (
        .addr       (look_addr),
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .line_blk   (line_blk),
        .idx        (look_idx),
        .tag        (look_tag),
        .hit        (hit),
        .byte_out   (cpu_rdata)
    );

    rcache_fill #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .BYTE_W (BYTE_W)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (cpu_addr),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .held_addr  (held_addr),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_blk     (wr_blk)
    );

endmodule

// File: rtl/rcache_chk.sv
module rcache_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned OFF_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid
);
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    logic beat_last;
    assign beat_last = mem_req && mem_valid && (mem_addr[OFF_W-1:0] == LAST_OFF);

    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    p_hit_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready) |=> !mem_req);

    p_fill_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> (mem_addr[OFF_W-1:0] == '0));

    p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid && !beat_last) |=>
            (mem_req && mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));

    p_block_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !beat_last) |=> (mem_req && $stable(mem_addr[ADDR_W-1:OFF_W])));

    p_fill_done_r4: assert property (@(posedge clk) disable iff (rst)
        beat_last |=> (!mem_req && cpu_ready));

    p_beat_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

endmodule

bind rcache_top rcache_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid)
);

// File: tb/rcache_top_tb.sv
module rcache_top_tb;
    localparam int BLK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       mem_req;
    logic [7:0] mem_addr;
    logic       mem_valid = 1'b0;
    logic [7:0] mem_rdata = '0;

    int  n_run = 0;
    int  n_fail = 0;
    bit  slow = 1'b0;
    bit  gap_tog = 1'b0;
    int  beat_m = 0;

    bit         ref_valid [4];
    logic [3:0] ref_tag   [4];

    logic [7:0] exp_q [$];
    string      req_q [$];

    always #2 clk = ~clk;

    rcache_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_addr  (cpu_addr),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] mem_byte(logic [7:0] a);
        return (a * 8'd29) ^ 8'hA5;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: answers at negedge, tracks the beat it expects
    always @(negedge clk) begin
        bit give;
        if (mem_valid) beat_m = beat_m + 1;
        if (!mem_req) beat_m = 0;
        give = mem_req && (!slow || gap_tog);
        gap_tog = ~gap_tog;
        if (give) chk(mem_addr[1:0] == 2'(beat_m), "R5", "beat offset", mem_addr[1:0], beat_m);
        mem_valid = give;
        mem_rdata = mem_byte(mem_addr);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cpu_req && cpu_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected delivery", cpu_rdata, 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(cpu_rdata == e, r, "read byte", cpu_rdata, e);
            end
        end
    end

    task automatic do_read(input logic [7:0] a, input string req);
        int  idx;
        bit  hit;
        int  waitc;
        idx = int'(a[3:2]);
        hit = ref_valid[idx] && (ref_tag[idx] == a[7:4]);
        exp_q.push_back(mem_byte(a));
        req_q.push_back(req);
        @(posedge clk);
        #1;
        cpu_req  = 1'b1;
        cpu_addr = a;
        waitc = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            waitc++;
            if (waitc > 200) break;
        end
        if (hit)
            chk(waitc == 0, req, "hit latency", waitc, 0);
        else if (!slow)
            chk(waitc == BLK + 1, req, "miss latency", waitc, BLK + 1);
        else
            chk(waitc > BLK + 1, req, "slow miss latency", waitc, BLK + 2);
        ref_valid[idx] = 1'b1;
        ref_tag[idx]   = a[7:4];
    endtask

    task automatic go_idle();
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            ref_valid[i] = 1'b0;
            ref_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R2", "ready in reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R2", "mem_req in reset", mem_req, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;

        // R2/R4: cold miss; R6/R7: neighbours then hit with matching bytes
        do_read(8'h35, "R2");
        do_read(8'h34, "R6");
        do_read(8'h36, "R7");
        do_read(8'h37, "R7");
        do_read(8'h35, "R3");
        go_idle();

        // R1: 0x9B is byte 3 of line 2, tag 9
        do_read(8'h9B, "R1");
        do_read(8'h98, "R1");
        // R8: same line, other tag, then back
        do_read(8'h1B, "R8");
        do_read(8'h9A, "R8");
        do_read(8'h35, "R8");
        go_idle();

        // R9: slow memory, then back-to-back lookups after delivery
        slow = 1'b1;
        do_read(8'hC2, "R9");
        do_read(8'hC1, "R9");
        do_read(8'h40, "R9");
        do_read(8'h43, "R9");
        slow = 1'b0;
        go_idle();

        do_read(8'h7F, "R4");
        do_read(8'h7C, "R6");
        go_idle();
        do_read(8'h9A, "R3");
        do_read(8'h42, "R7");
        go_idle();

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
        chk(mem_req == 1'b0, "R4", "memory quiet at end", mem_req, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule